// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block produces real-time-clock style interrupt flags (seconds update, alarm and periodic) without a dedicated RTC interrupt line. It owns one comparator that it schedules against an external free-running 32-bit counter. Each time the counter reaches the comparator, the engine examines the current time of day and its stored settings, raises the matching flags, and moves the comparator forward by one tick interval. If the counter has already run past several intervals, the engine keeps advancing the comparator until it is ahead again. It counts those skipped ticks and credits them to the periodic divider.

The default tick rate is 64 Hz of counter time. A periodic request is given as a rate code equal to log2 of the rate in Hz, from 1 (2 Hz) to 13 (8192 Hz). At or below 64 Hz the tick stays at 64 Hz and ticks are divided down. Above 64 Hz the tick interval itself shrinks. The host loads the enables, the alarm time and the rate code through simple load strobes. It reads the result from a flag word and a one-clock interrupt pulse.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset `flags_o`, `irq_o`, `lost_o` and `chan_on_o` are zero. The stored enables are all clear, the stored alarm is 0:0:0, the rate code is 6 (64 Hz) and the recorded seconds value is 0.
- R2: When `ens_ld_i` loads a nonzero enable set while all enables are clear, the comparator becomes the counter value at that edge plus one tick interval, and `chan_on_o` rises. The interval is the counter frequency divided by 64, unless the periodic enable (bit 2) is in the new set and the rate code exceeds 6. In that case the interval is the counter frequency shifted right by the rate code.
- R3: Loading an all-clear enable set turns the comparator channel off at that edge (`chan_on_o` low), and no interrupt occurs while it stays off.
- R4: A tick occurs when the signed 32-bit difference counter minus comparator is zero or positive. The comparator then advances by one interval per clock for as long as that difference stays positive. The number of advances beyond the first is reported on `lost_o` once the tick completes.
- R5: With the update enable (bit 0) set, a tick whose seconds input differs from the recorded seconds raises the update flag (bit 4) and records the new seconds value. A tick with unchanged seconds raises nothing.
- R6: With the alarm enable (bit 1) set, a tick raises the alarm flag (bit 5) only when hours, minutes and seconds all equal the stored alarm time.
- R7: With the periodic enable set and a rate code k of 6 or less, each tick adds one to a periodic count. When the count reaches 2^(6-k), the periodic flag (bit 6) is raised and the count returns to zero. Loading a rate code clears the count.
- R8: With the periodic enable set and a rate code above 6, the tick interval becomes the counter frequency shifted right by the rate code, and every tick raises the periodic flag.
- R9: When periodic interrupts are enabled, the lost ticks of a catch-up are added to the periodic count together with the tick itself.
- R10: A loaded rate code below 1 is treated as 1, and one above 13 is treated as 13.
- R11: When any flag is raised, `flags_o` is loaded with bit 7 set, bits 15:8 equal to 1, bits 3:0 zero and bits 6:4 carrying the raised flags. `irq_o` pulses high for exactly one clock, and `flags_o` holds its value until the next raised flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 32 | Free-running counter value |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hrs_i | input | 8 | Current hours |
| alm_ld_i | input | 1 | Load strobe for the alarm time |
| alm_sec_i | input | 8 | Alarm seconds to load |
| alm_min_i | input | 8 | Alarm minutes to load |
| alm_hrs_i | input | 8 | Alarm hours to load |
| ens_ld_i | input | 1 | Load strobe for the enable set |
| ens_i | input | 3 | Enables: bit 0 update, bit 1 alarm, bit 2 periodic |
| freq_ld_i | input | 1 | Load strobe for the periodic rate code |
| freq_log2_i | input | 4 | Periodic rate code, log2 of the rate in Hz |
| flags_o | output | 16 | Flag word of the latest interrupt |
| irq_o | output | 1 | One-clock interrupt pulse |
| lost_o | output | 8 | Ticks skipped during the latest catch-up |
| cmp_o | output | 32 | Current comparator value |
| chan_on_o | output | 1 | Comparator channel active |

## Verification
The periodic function is swept across every rate code from 1 to 13, plus two out-of-range codes. The spacing between successive pulses is compared with the spacing computed from the code, which separates the divide-down region from the interval-shrinking region and shows where they meet at 64 Hz. Update and alarm are driven with seconds held, seconds changed, a full time match and a match spoiled only in the hours, so that a flag that depends on the wrong field shows up. A counter jump that lands a known number of intervals past the comparator tells a design that credits lost ticks from one that only counts them. Enabling from the all-clear state, with and without the periodic bit at a high rate, shows which interval the reload uses.

// File: rtl/rie_pkg.sv
package rie_pkg;
  // enable set bit positions
  localparam int EN_W   = 3;
  localparam int EN_UPD = 0;
  localparam int EN_ALM = 1;
  localparam int EN_PER = 2;

  // flag word layout
  localparam int FLAG_W    = 16;
  localparam int FLAG_UPD  = 4;
  localparam int FLAG_ALM  = 5;
  localparam int FLAG_PER  = 6;
  localparam int FLAG_IRQ  = 7;
  localparam int NUM_LSB   = 8;
  localparam int NUM_W     = 8;

  typedef enum logic [1:0] {
    SCH_OFF   = 2'd0,
    SCH_ARMED = 2'd1,
    SCH_CATCH = 2'd2
  } sch_state_e;
endpackage

// File: rtl/rie_rate.sv
module rie_rate #(
  parameter int CW        = 32,
  parameter int CODE_W    = 4,
  parameter int CNT_LOG2  = 16,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13,
  parameter int LIM_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_ld_i,
  input  logic [CODE_W-1:0] freq_log2_i,
  output logic [LIM_W-1:0]  limit_o,
  output logic [CW-1:0]     base_delta_o,
  output logic [CW-1:0]     fast_delta_o,
  output logic              use_fast_o
);
  localparam int SW = $clog2(CNT_LOG2 + 1);
  localparam logic [CW-1:0] BASE_DELTA = CW'(1) << (CNT_LOG2 - BASE_LOG2);

  logic [CODE_W-1:0] code_q, code_d;
  logic [SW-1:0]     fast_sh;

  // clamp the requested code into the supported range
  always_comb begin
    if (freq_log2_i < CODE_W'(MIN_LOG2)) begin
      code_d = CODE_W'(MIN_LOG2);
    end else if (freq_log2_i > CODE_W'(MAX_LOG2)) begin
      code_d = CODE_W'(MAX_LOG2);
    end else begin
      code_d = freq_log2_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_W'(BASE_LOG2);
    end else if (freq_ld_i) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    use_fast_o   = (code_q > CODE_W'(BASE_LOG2));
    fast_sh      = SW'(CNT_LOG2) - SW'(code_q);
    fast_delta_o = CW'(1) << fast_sh;
    base_delta_o = BASE_DELTA;
    if (use_fast_o) begin
      limit_o = LIM_W'(1);
    end else begin
      limit_o = LIM_W'(1) << (CODE_W'(BASE_LOG2) - code_q);
    end
  end
endmodule

// File: rtl/rie_sched.sv
module rie_sched
  import rie_pkg::*;
#(
  parameter int CW     = 32,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     count_i,
  input  logic              ens_ld_i,
  input  logic [EN_W-1:0]   ens_new_i,
  input  logic              per_cur_i,
  input  logic [CW-1:0]     base_delta_i,
  input  logic [CW-1:0]     fast_delta_i,
  input  logic              use_fast_i,
  output logic [CW-1:0]     cmp_o,
  output logic              chan_on_o,
  output logic              done_o,
  output logic [LOST_W-1:0] lost_o
);
  sch_state_e        st_q, st_d;
  logic [CW-1:0]     cmp_q, cmp_d;
  logic [LOST_W-1:0] lost_q, lost_d;
  logic [CW-1:0]     gap;
  logic              reached, ahead_strict;
  logic [CW-1:0]     delta_cur, delta_new;

  always_comb begin
    gap          = count_i - cmp_q;
    reached      = ~gap[CW-1];
    ahead_strict = reached && (gap != '0);
    delta_cur    = (per_cur_i && use_fast_i) ? fast_delta_i : base_delta_i;
    delta_new    = (ens_new_i[EN_PER] && use_fast_i) ? fast_delta_i : base_delta_i;
  end

  // next-state: tick detect, then one comparator advance per clock
  always_comb begin
    st_d   = st_q;
    cmp_d  = cmp_q;
    lost_d = lost_q;
    done_o = 1'b0;
    unique case (st_q)
      SCH_ARMED: begin
        if (reached) begin
          cmp_d  = cmp_q + delta_cur;
          lost_d = '0;
          st_d   = SCH_CATCH;
        end
      end
      SCH_CATCH: begin
        if (ahead_strict) begin
          cmp_d = cmp_q + delta_cur;
          if (lost_q != '1) begin
            lost_d = lost_q + LOST_W'(1);
          end
        end else begin
          done_o = 1'b1;
          st_d   = SCH_ARMED;
        end
      end
      default: begin
      end
    endcase
    if (ens_ld_i) begin
      if (ens_new_i == '0) begin
        st_d   = SCH_OFF;
        done_o = 1'b0;
      end else if (st_q == SCH_OFF) begin
        cmp_d = count_i + delta_new;
        st_d  = SCH_ARMED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCH_OFF;
      cmp_q  <= '0;
      lost_q <= '0;
    end else begin
      st_q   <= st_d;
      cmp_q  <= cmp_d;
      lost_q <= lost_d;
    end
  end

  assign cmp_o     = cmp_q;
  assign chan_on_o = (st_q != SCH_OFF);
  assign lost_o    = lost_q;
endmodule

// File: rtl/rie_flags.sv
module rie_flags
  import rie_pkg::*;
#(
  parameter int TW     = 8,
  parameter int LOST_W = 8,
  parameter int LIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [LOST_W-1:0] lost_i,
  input  logic [EN_W-1:0]   ens_i,
  input  logic [TW-1:0]     sec_i,
  input  logic [TW-1:0]     min_i,
  input  logic [TW-1:0]     hrs_i,
  input  logic [TW-1:0]     alm_sec_i,
  input  logic [TW-1:0]     alm_min_i,
  input  logic [TW-1:0]     alm_hrs_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              freq_ld_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic [LOST_W-1:0] lost_o
);
  localparam int SUM_W = ((LOST_W > LIM_W) ? LOST_W : LIM_W) + 1;

  logic [TW-1:0]     prev_sec_q;
  logic [LIM_W-1:0]  pie_cnt_q, pie_cnt_d;
  logic [FLAG_W-1:0] flags_q, word;
  logic              irq_q, irq_d;
  logic [LOST_W-1:0] lost_q;
  logic [SUM_W-1:0]  sum;
  logic              hit_upd, hit_alm, hit_per, any_hit;
  logic              prev_en, flags_en;

  always_comb begin
    hit_upd = ens_i[EN_UPD] && (sec_i != prev_sec_q);
    hit_alm = ens_i[EN_ALM] && (sec_i == alm_sec_i) &&
              (min_i == alm_min_i) && (hrs_i == alm_hrs_i);
    sum     = SUM_W'(pie_cnt_q) + SUM_W'(lost_i) + SUM_W'(1);
    hit_per = ens_i[EN_PER] && (sum >= SUM_W'(limit_i));
    any_hit = hit_upd | hit_alm | hit_per;

    prev_en  = done_i && hit_upd;
    flags_en = done_i && any_hit;
    irq_d    = flags_en;

    pie_cnt_d = pie_cnt_q;
    if (freq_ld_i) begin
      pie_cnt_d = '0;
    end else if (done_i && ens_i[EN_PER]) begin
      pie_cnt_d = hit_per ? '0 : LIM_W'(sum);
    end

    word                            = '0;
    word[NUM_LSB +: NUM_W]          = NUM_W'(1);
    word[FLAG_IRQ]                  = 1'b1;
    word[FLAG_PER]                  = hit_per;
    word[FLAG_ALM]                  = hit_alm;
    word[FLAG_UPD]                  = hit_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sec_q <= '0;
      pie_cnt_q  <= '0;
      flags_q    <= '0;
      irq_q      <= 1'b0;
      lost_q     <= '0;
    end else begin
      pie_cnt_q <= pie_cnt_d;
      irq_q     <= irq_d;
      if (prev_en) begin
        prev_sec_q <= sec_i;
      end
      if (flags_en) begin
        flags_q <= word;
      end
      if (done_i) begin
        lost_q <= lost_i;
      end
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
  assign lost_o  = lost_q;
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rie_pkg::*;
#(
  parameter int CW        = 32,
  parameter int TW        = 8,
  parameter int CODE_W    = 4,
  parameter int LOST_W    = 8,
  parameter int CNT_LOG2  = 16,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     count_i,
  input  logic [TW-1:0]     sec_i,
  input  logic [TW-1:0]     min_i,
  input  logic [TW-1:0]     hrs_i,
  input  logic              alm_ld_i,
  input  logic [TW-1:0]     alm_sec_i,
  input  logic [TW-1:0]     alm_min_i,
  input  logic [TW-1:0]     alm_hrs_i,
  input  logic              ens_ld_i,
  input  logic [EN_W-1:0]   ens_i,
  input  logic              freq_ld_i,
  input  logic [CODE_W-1:0] freq_log2_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic [LOST_W-1:0] lost_o,
  output logic [CW-1:0]     cmp_o,
  output logic              chan_on_o
);
  localparam int LIM_W = BASE_LOG2 - MIN_LOG2 + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic [EN_W-1:0] ens_q;
  logic [TW-1:0]   alm_sec_q, alm_min_q, alm_hrs_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ens_q     <= '0;
      alm_sec_q <= '0;
      alm_min_q <= '0;
      alm_hrs_q <= '0;
    end else begin
      if (ens_ld_i) begin
        ens_q <= ens_i;
      end
      if (alm_ld_i) begin
        alm_sec_q <= alm_sec_i;
        alm_min_q <= alm_min_i;
        alm_hrs_q <= alm_hrs_i;
      end
    end
  end

  logic [LIM_W-1:0]  limit;
  logic [CW-1:0]     base_delta, fast_delta;
  logic              use_fast;
  logic              tick_done;
  logic [LOST_W-1:0] tick_lost;

  rie_rate #(
    .CW(CW), .CODE_W(CODE_W), .CNT_LOG2(CNT_LOG2), .BASE_LOG2(BASE_LOG2),
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .LIM_W(LIM_W)
  ) u_rate (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .freq_ld_i    (freq_ld_i),
    .freq_log2_i  (freq_log2_i),
    .limit_o      (limit),
    .base_delta_o (base_delta),
    .fast_delta_o (fast_delta),
    .use_fast_o   (use_fast)
  );

  rie_sched #(.CW(CW), .LOST_W(LOST_W)) u_sched (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .count_i      (count_i),
    .ens_ld_i     (ens_ld_i),
    .ens_new_i    (ens_i),
    .per_cur_i    (ens_q[EN_PER]),
    .base_delta_i (base_delta),
    .fast_delta_i (fast_delta),
    .use_fast_i   (use_fast),
    .cmp_o        (cmp_o),
    .chan_on_o    (chan_on_o),
    .done_o       (tick_done),
    .lost_o       (tick_lost)
  );

  rie_flags #(.TW(TW), .LOST_W(LOST_W), .LIM_W(LIM_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .done_i    (tick_done),
    .lost_i    (tick_lost),
    .ens_i     (ens_q),
    .sec_i     (sec_i),
    .min_i     (min_i),
    .hrs_i     (hrs_i),
    .alm_sec_i (alm_sec_q),
    .alm_min_i (alm_min_q),
    .alm_hrs_i (alm_hrs_q),
    .limit_i   (limit),
    .freq_ld_i (freq_ld_i),
    .flags_o   (flags_o),
    .irq_o     (irq_o),
    .lost_o    (lost_o)
  );
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
  parameter int CW = 32,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic [15:0]   flags_o,
  input logic          chan_on_o,
  input logic [CW-1:0] cmp_o,
  input logic [CW-1:0] count_i,
  input logic [2:0]    ens_q,
  input logic          per_new,
  input logic          ens_ld_i,
  input logic [CW-1:0] base_delta,
  input logic [CW-1:0] fast_delta,
  input logic          use_fast,
  input logic [TW-1:0] sec_i,
  input logic [TW-1:0] min_i,
  input logic [TW-1:0] hrs_i,
  input logic [TW-1:0] alm_sec_q,
  input logic [TW-1:0] alm_min_q,
  input logic [TW-1:0] alm_hrs_q
);
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[15:8] == 8'd1) && flags_o[7] &&
              (flags_o[6:4] != 3'b000) && (flags_o[3:0] == 4'b0000));

  assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ens_q == 3'b000) |-> !chan_on_o);

  assert_per_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[6]) |-> $past(ens_q[2]));

  assert_alarm_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flags_o[5]) |-> $past((hrs_i == alm_hrs_q) &&
                                    (min_i == alm_min_q) &&
                                    (sec_i == alm_sec_q)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on_o && $past(chan_on_o) && !$past(ens_ld_i) && (cmp_o != $past(cmp_o)))
      |-> ((cmp_o - $past(cmp_o)) ==
           ($past(ens_q[2] && use_fast) ? $past(fast_delta) : $past(base_delta))));

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_on_o) |-> ((cmp_o - $past(count_i)) ==
           ($past(per_new && use_fast) ? $past(fast_delta) : $past(base_delta))));
endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .irq_o      (irq_o),
  .flags_o    (flags_o),
  .chan_on_o  (chan_on_o),
  .cmp_o      (cmp_o),
  .count_i    (count_i),
  .ens_q      (ens_q),
  .per_new    (ens_i[2]),
  .ens_ld_i   (ens_ld_i),
  .base_delta (base_delta),
  .fast_delta (fast_delta),
  .use_fast   (use_fast),
  .sec_i      (sec_i),
  .min_i      (min_i),
  .hrs_i      (hrs_i),
  .alm_sec_q  (alm_sec_q),
  .alm_min_q  (alm_min_q),
  .alm_hrs_q  (alm_hrs_q)
);

// File: tb/rtc_irq_emu_tb_top.sv
module rtc_irq_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 4;
  localparam int CNT_HZ     = 65536;
  localparam int BASE_DELTA = CNT_HZ / 64;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] count_i = 32'd0;
  logic [7:0]  sec_i, min_i, hrs_i;
  logic        alm_ld_i;
  logic [7:0]  alm_sec_i, alm_min_i, alm_hrs_i;
  logic        ens_ld_i;
  logic [2:0]  ens_i;
  logic        freq_ld_i;
  logic [3:0]  freq_log2_i;
  logic [15:0] flags_o;
  logic        irq_o;
  logic [7:0]  lost_o;
  logic [31:0] cmp_o;
  logic        chan_on_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_emu dut_i (
    .clk(clk), .rst_n(rst_n), .count_i(count_i),
    .sec_i(sec_i), .min_i(min_i), .hrs_i(hrs_i),
    .alm_ld_i(alm_ld_i), .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hrs_i(alm_hrs_i),
    .ens_ld_i(ens_ld_i), .ens_i(ens_i),
    .freq_ld_i(freq_ld_i), .freq_log2_i(freq_log2_i),
    .flags_o(flags_o), .irq_o(irq_o), .lost_o(lost_o),
    .cmp_o(cmp_o), .chan_on_o(chan_on_o)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          irq_cnt = 0;
  int          last_irq_cyc = 0;
  logic [15:0] last_flags = 16'h0;
  logic [31:0] jump_add = 32'd0;
  bit          finished = 1'b0;

  // counter stimulus and interrupt monitor, both away from the active edge
  always @(negedge clk) begin
    cyc     <= cyc + 1;
    count_i <= count_i + STEP + jump_add;
    if (irq_o === 1'b1) begin
      irq_cnt      <= irq_cnt + 1;
      last_irq_cyc <= cyc;
      last_flags   <= flags_o;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_ens(input logic [2:0] v);
    ens_i = v; ens_ld_i = 1'b1;
    step_clk(1);
    ens_ld_i = 1'b0;
  endtask

  task automatic set_freq(input logic [3:0] k);
    freq_log2_i = k; freq_ld_i = 1'b1;
    step_clk(1);
    freq_ld_i = 1'b0;
  endtask

  task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    alm_hrs_i = h; alm_min_i = m; alm_sec_i = s; alm_ld_i = 1'b1;
    step_clk(1);
    alm_ld_i = 1'b0;
  endtask

  task automatic wait_irq(input int maxc, output bit got);
    int start;
    start = irq_cnt;
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      step_clk(1);
      if (irq_cnt != start) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic no_irq(input string req, input int n);
    int start;
    start = irq_cnt;
    step_clk(n);
    chk(req, "interrupts in quiet window", irq_cnt - start, 0);
  endtask

  function automatic int exp_gap(input int k);
    int kc;
    kc = (k < 1) ? 1 : ((k > 13) ? 13 : k);
    if (kc <= 6) return ((1 << (6 - kc)) * BASE_DELTA) / STEP;
    else return (CNT_HZ >> kc) / STEP;
  endfunction

  // spacing of periodic pulses once the new rate has settled
  task automatic measure(input string req, input int k);
    bit got;
    int c2;
    set_freq(4'(k));
    wait_irq(40000, got);
    wait_irq(40000, got);
    c2 = last_irq_cyc;
    wait_irq(40000, got);
    chk(req, $sformatf("pulse spacing for code %0d", k), last_irq_cyc - c2, exp_gap(k));
    chk(req, "periodic flag word", last_flags, 16'h01C0);
  endtask

  initial begin
    bit got;
    int t0;
    rst_n = 1'b0;
    sec_i = 8'd0; min_i = 8'd0; hrs_i = 8'd0;
    alm_ld_i = 1'b0; alm_sec_i = 8'd0; alm_min_i = 8'd0; alm_hrs_i = 8'd0;
    ens_ld_i = 1'b0; ens_i = 3'b000;
    freq_ld_i = 1'b0; freq_log2_i = 4'd0;
    step_clk(4);
    rst_n = 1'b1;
    step_clk(4);

    // R1: reset state
    chk("R1", "flags_o", flags_o, 0);
    chk("R1", "irq_o", irq_o, 0);
    chk("R1", "lost_o", lost_o, 0);
    chk("R1", "chan_on_o", chan_on_o, 0);

    // R1/R7: default rate code 6 gives a periodic pulse every base tick
    set_ens(3'b100);
    chk("R2", "reload interval, periodic at default code", 32'(cmp_o - count_i), BASE_DELTA);
    chk("R2", "chan_on_o after enable", chan_on_o, 1);
    wait_irq(2000, got);
    t0 = last_irq_cyc;
    wait_irq(2000, got);
    chk("R1", "default periodic spacing", last_irq_cyc - t0, BASE_DELTA / STEP);
    chk("R4", "lost_o without catch-up", lost_o, 0);
    set_ens(3'b000);

    // R5: update flag on seconds change
    sec_i = 8'd5;
    set_ens(3'b001);
    chk("R2", "reload interval, update only", 32'(cmp_o - count_i), BASE_DELTA);
    wait_irq(2000, got);
    chk("R5", "update irq seen", got, 1);
    chk("R11", "update word", last_flags, 16'h0190);
    no_irq("R5", 800);
    sec_i = 8'd6;
    wait_irq(400, got);
    chk("R5", "update irq after seconds change", got, 1);
    chk("R11", "update word again", last_flags, 16'h0190);
    chk("R11", "flags_o held after pulse", flags_o, 16'h0190);

    // R6: alarm only on full match
    set_alarm(8'd1, 8'd2, 8'd3);
    hrs_i = 8'd1; min_i = 8'd2; sec_i = 8'd4;
    set_ens(3'b010);
    no_irq("R6", 800);
    sec_i = 8'd3;
    wait_irq(400, got);
    chk("R6", "alarm irq on match", got, 1);
    chk("R6", "alarm word", last_flags, 16'h01A0);
    hrs_i = 8'd9;
    step_clk(20);
    no_irq("R6", 800);

    // R11: all three flags in one tick (seconds 3 differs from recorded 6)
    hrs_i = 8'd1;
    set_freq(4'd6);
    set_ens(3'b111);
    wait_irq(400, got);
    chk("R11", "combined word", last_flags, 16'h01F0);

    // R3: channel off
    set_ens(3'b000);
    chk("R3", "chan_on_o after clear", chan_on_o, 0);
    no_irq("R3", 1500);

    // R2/R8: reload interval choice with a high rate code
    set_freq(4'd13);
    set_ens(3'b001);
    chk("R8", "reload interval without periodic", 32'(cmp_o - count_i), BASE_DELTA);
    set_ens(3'b000);
    set_ens(3'b100);
    chk("R8", "reload interval with periodic at code 13", 32'(cmp_o - count_i), CNT_HZ >> 13);

    // R7/R8: sweep every rate code
    for (int k = 1; k <= 13; k++) begin
      measure((k <= 6) ? "R7" : "R8", k);
    end

    // R10: out-of-range codes
    measure("R10", 15);
    measure("R10", 0);

    // R9/R4: lost ticks credited to the periodic count (code 3, limit 8)
    set_freq(4'd3);
    wait_irq(20000, got);
    wait_irq(20000, got);
    chk("R4", "lost_o on regular tick", lost_o, 0);
    step_clk(10);
    jump_add = cmp_o + 32'(3 * BASE_DELTA + 100) - count_i - 32'(STEP);
    step_clk(1);
    jump_add = 32'd0;
    step_clk(19);
    chk("R4", "lost_o after counter jump", lost_o, 3);
    no_irq("R9", 880);
    wait_irq(300, got);
    chk("R9", "periodic pulse after credited ticks", got, 1);
    chk("R9", "periodic word", last_flags, 16'h01C0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule